// File: doc/BRIEF.md
# Reloadable Periodic Interval Timer

This block produces a level interrupt once in every period. Software sets the period by writing a reload value. The tick rate in hertz is the integer quotient of 1000 divided by (reload + 1). The period is one second divided by that rate, also an integer quotient. One second is `TICKS_PER_SEC` cycles of a fixed-frequency clock-enable input (`tick_en`), and only cycles with that enable high advance the timer. When a reload value of 1000 or more would give a rate of zero, the rate is taken as one, so the period saturates at one second.

The block has two registers. A write to the reload register lowers the interrupt, starts a new period count from that write, and starts the period calculation. A sequential divider does this calculation through three named FSM states. `CALC_HOLD` keeps a valid period. `CALC_RATE` divides 1000 by (reload + 1). `CALC_PERIOD` divides `TICKS_PER_SEC` by the rate. The transitions are:
- `load_start`: a write in any state goes to `CALC_RATE`, or to `CALC_PERIOD` when the reload saturates.
- `rate_done`: `CALC_RATE` goes to `CALC_PERIOD`.
- `period_done`: `CALC_PERIOD` goes to `CALC_HOLD`.

A read of the acknowledge register returns zero and lowers the interrupt. The interrupt itself is a two-state machine:
- `IRQ_CLEAR` goes to `IRQ_RAISED` on a period expiry.
- `IRQ_RAISED` goes back to `IRQ_CLEAR` on an acknowledge read or on a reload write.

Top module: `pit_interval_timer`

## Requirements
- R1: After reset `irq` is low, the reload value is 0 and the period is `TICKS_PER_SEC/1000` enabled cycles. `irq` rises after that many enabled clock edges following the release of reset.
- R2: With reload r below 1000, the period is `TICKS_PER_SEC / (1000/(r+1))` enabled cycles. Both divisions truncate, and the period is never less than one cycle.
- R3: A reload value of 1000 or more gives a period of exactly `TICKS_PER_SEC` enabled cycles.
- R4: A write to the reload register (`reload_we` high at a clock edge) lowers `irq` after that edge and restarts the period count from that edge. A write at the same edge as an expiry wins, and `irq` ends low.
- R5: At each expiry `irq` is high after that edge and the next period begins at once. The next expiry is one period after the previous one, whenever the acknowledge happened.
- R6: An acknowledge read (`ack_re` high at a clock edge) lowers `irq` after that edge. `ack_rdata` is always zero.
- R7: When an acknowledge read and an expiry happen at the same edge, `irq` stays high.
- R8: Clock edges with `tick_en` low do not advance the period count.
- R9: `irq` is a level. It stays high across later expiries until an acknowledge read or a reload write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Fixed-frequency count enable; `TICKS_PER_SEC` enabled cycles make one second |
| reload_we | input | 1 | Write strobe of the reload register |
| reload_wdata | input | RELOAD_W | Reload value to write |
| ack_re | input | 1 | Read strobe of the acknowledge register |
| ack_rdata | output | DATA_W | Read data of the acknowledge register, always zero |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check on every cycle the following local rules:
- after a write, `irq` is low;
- an expiry without a write leaves `irq` high;
- an acknowledge without an expiry or a write clears `irq`;
- every rising edge of `irq` comes from an expiry;
- the count holds while `tick_en` is low;
- a held period is never zero.

Only the bench scenarios can show that the period lengths match the integer-division formula for each reload value, including saturation. The same applies to the period running on from the expiry rather than from the acknowledge, and to disabled cycles extending a period by exactly their number.

// File: rtl/pit_pkg.sv
package pit_pkg;

    // Milliseconds in one second; the rate is this divided by (reload + 1)
    localparam int unsigned MS_PER_SEC = 1000;
    localparam int unsigned MS_BITS    = $clog2(MS_PER_SEC);

    typedef enum logic [1:0] {
        CALC_HOLD,
        CALC_RATE,
        CALC_PERIOD
    } calc_state_e;

    typedef enum logic {
        IRQ_CLEAR,
        IRQ_RAISED
    } irq_state_e;

endpackage

// File: rtl/pit_divider.sv
module pit_divider #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int unsigned SW = $clog2(W + 1);

    logic [W-1:0]  quo_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  den_q;
    logic [SW-1:0] steps_q;
    logic [W:0]    shifted;
    logic [W:0]    diff;
    logic          fit;

    // One restoring step: shift in the next dividend bit, subtract if it fits
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, den_q};
        fit     = (shifted >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q   <= '0;
            rem_q   <= '0;
            den_q   <= '0;
            steps_q <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else if (start) begin
            quo_q   <= dividend;
            rem_q   <= '0;
            den_q   <= divisor;
            steps_q <= SW'(W);
            busy    <= 1'b1;
            done    <= 1'b0;
        end else if (busy) begin
            quo_q   <= {quo_q[W-2:0], fit};
            rem_q   <= fit ? diff[W-1:0] : shifted[W-1:0];
            steps_q <= steps_q - SW'(1);
            if (steps_q == SW'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    assign quotient = quo_q;

    // R2
    div_done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R2
    div_done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/pit_period_calc.sv
module pit_period_calc
    import pit_pkg::*;
#(
    parameter int unsigned RELOAD_W      = 32,
    parameter int unsigned TICKS_PER_SEC = 1_000_000,
    parameter int unsigned DIV_W         = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [RELOAD_W-1:0] reload,
    output logic                period_ok,
    output logic [DIV_W-1:0]    period
);
    localparam int unsigned      RP_RAW       = TICKS_PER_SEC / MS_PER_SEC;
    localparam logic [DIV_W-1:0] TPS_V        = DIV_W'(TICKS_PER_SEC);
    localparam logic [DIV_W-1:0] MS_V         = DIV_W'(MS_PER_SEC);
    localparam logic [DIV_W-1:0] RESET_PERIOD = (RP_RAW == 0) ? DIV_W'(1) : DIV_W'(RP_RAW);

    calc_state_e      st_q;
    calc_state_e      st_d;
    logic             saturate;
    logic             div_start;
    logic [DIV_W-1:0] div_num;
    logic [DIV_W-1:0] div_den;
    logic             div_busy;
    logic             div_done;
    logic [DIV_W-1:0] div_quo;

    assign saturate = (reload >= RELOAD_W'(MS_PER_SEC));

    pit_divider #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_num),
        .divisor  (div_den),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_quo)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CALC_HOLD;
        else        st_q <= st_d;
    end

    // Next state: load_start, rate_done, period_done
    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d = saturate ? CALC_PERIOD : CALC_RATE;
        end else begin
            unique case (st_q)
                CALC_HOLD:   st_d = CALC_HOLD;
                CALC_RATE:   if (div_done) st_d = CALC_PERIOD;
                CALC_PERIOD: if (div_done) st_d = CALC_HOLD;
                default:     st_d = CALC_HOLD;
            endcase
        end
    end

    // Divider control outputs
    always_comb begin
        div_start = 1'b0;
        div_num   = TPS_V;
        div_den   = DIV_W'(1);
        if (load) begin
            div_start = 1'b1;
            if (!saturate) begin
                div_num = MS_V;
                div_den = DIV_W'(reload[MS_BITS-1:0]) + DIV_W'(1);
            end
        end else begin
            unique case (st_q)
                CALC_HOLD:   div_start = 1'b0;
                CALC_RATE: begin
                    div_start = div_done;
                    div_den   = div_quo;
                end
                CALC_PERIOD: div_start = 1'b0;
                default:     div_start = 1'b0;
            endcase
        end
    end

    // Period register, clamped to at least one enabled cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period    <= RESET_PERIOD;
            period_ok <= 1'b1;
        end else if (load) begin
            period_ok <= 1'b0;
        end else if (st_q == CALC_PERIOD && div_done) begin
            period    <= (div_quo == '0) ? DIV_W'(1) : div_quo;
            period_ok <= 1'b1;
        end
    end

    // R2
    period_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_ok |-> (period != '0));

    // R2
    hold_has_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CALC_HOLD) |-> period_ok);

    // R4
    load_voids_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !period_ok);

endmodule

// File: rtl/pit_tick_counter.sv
module pit_tick_counter
    import pit_pkg::*;
#(
    parameter int unsigned DIV_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load,
    input  logic             ack,
    input  logic             period_ok,
    input  logic [DIV_W-1:0] period,
    output logic             irq
);
    logic [DIV_W-1:0] cnt_q;
    logic             expire;
    irq_state_e       irq_q;
    irq_state_e       irq_d;

    assign expire = tick_en && period_ok && (cnt_q >= period - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (load || expire)         cnt_q <= '0;
        else if (tick_en && cnt_q != '1) cnt_q <= cnt_q + DIV_W'(1);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= IRQ_CLEAR;
        else        irq_q <= irq_d;
    end

    // Priority: write, then expiry, then acknowledge
    always_comb begin
        irq_d = irq_q;
        unique case (irq_q)
            IRQ_CLEAR:  if (!load && expire) irq_d = IRQ_RAISED;
            IRQ_RAISED: if (load || (ack && !expire)) irq_d = IRQ_CLEAR;
            default:    irq_d = IRQ_CLEAR;
        endcase
    end

    // Output
    always_comb begin
        irq = (irq_q == IRQ_RAISED);
    end

    // R4
    irq_low_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !irq);

    // R7
    expiry_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load) |=> irq);

    // R6
    ack_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !expire && !load) |=> !irq);

    // R5
    irq_rise_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(expire));

    // R8
    count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/pit_interval_timer.sv
module pit_interval_timer
    import pit_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 1_000_000,
    parameter int unsigned RELOAD_W      = 32,
    parameter int unsigned DATA_W        = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                reload_we,
    input  logic [RELOAD_W-1:0] reload_wdata,
    input  logic                ack_re,
    output logic [DATA_W-1:0]   ack_rdata,
    output logic                irq
);
    localparam int unsigned TPS_BITS = $clog2(TICKS_PER_SEC + 1);
    localparam int unsigned DIV_W    = (TPS_BITS > MS_BITS + 1) ? TPS_BITS : MS_BITS + 1;

    logic             period_ok;
    logic [DIV_W-1:0] period;

    pit_period_calc #(
        .RELOAD_W      (RELOAD_W),
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .DIV_W         (DIV_W)
    ) u_calc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (reload_we),
        .reload    (reload_wdata),
        .period_ok (period_ok),
        .period    (period)
    );

    pit_tick_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .load      (reload_we),
        .ack       (ack_re),
        .period_ok (period_ok),
        .period    (period),
        .irq       (irq)
    );

    assign ack_rdata = '0;

    // R6
    ack_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_re |-> (ack_rdata == '0));

endmodule

// File: tb/pit_interval_timer_test.sv
module pit_interval_timer_test;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned TPS        = 40000;
    localparam int unsigned NVEC       = 7;

    // Reload values and the periods expected from R2 (hand-computed quotients)
    localparam int unsigned VEC_RELOAD [NVEC] = '{0, 1, 2, 3, 6, 9, 499};
    localparam int unsigned VEC_PERIOD [NVEC] = '{40, 80, 120, 160, 281, 400, 20000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        reload_we = 1'b0;
    logic [31:0] reload_wdata = '0;
    logic        ack_re = 1'b0;
    logic [31:0] ack_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pit_interval_timer #(.TICKS_PER_SEC(TPS)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .reload_we    (reload_we),
        .reload_wdata (reload_wdata),
        .ack_re       (ack_re),
        .ack_rdata    (ack_rdata),
        .irq          (irq)
    );

    task automatic check(input string req, input longint got, input longint exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // From a falling edge: let n rising edges pass, stop on the next falling edge
    task automatic tick(input int unsigned n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [31:0] v);
        reload_we    = 1'b1;
        reload_wdata = v;
        @(posedge clk);
        @(negedge clk);
        reload_we    = 1'b0;
    endtask

    task automatic do_ack(input string req);
        ack_re = 1'b1;
        check(req, ack_rdata, 0);
        @(posedge clk);
        @(negedge clk);
        ack_re = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state and first period with the reset reload of 0
        repeat (3) @(negedge clk);
        check("R1 irq in reset", irq, 0);
        check("R1 rdata in reset", ack_rdata, 0);
        rst_n = 1'b1;
        tick(39);
        check("R1 before first expiry", irq, 0);
        tick(1);
        check("R1 first expiry", irq, 1);

        // Table of reload values walked by one loop
        for (int i = 0; i < NVEC; i++) begin
            int unsigned p;
            p = VEC_PERIOD[i];
            do_write(VEC_RELOAD[i]);
            check("R4 write lowers irq", irq, 0);
            tick(p - 1);
            check("R2 one cycle before expiry", irq, 0);
            tick(1);
            check("R2 expiry at period", irq, 1);
            tick(p);
            check("R9 irq held over second expiry", irq, 1);
            do_ack("R6 read data zero");
            check("R6 ack lowers irq", irq, 0);
            tick(p - 2);
            check("R5 no early expiry after ack", irq, 0);
            tick(1);
            check("R5 period runs from expiry", irq, 1);
        end

        // R7: acknowledge at the same edge as an expiry
        do_write(0);
        tick(40);
        check("R7 first expiry", irq, 1);
        tick(39);
        do_ack("R7 read data zero");
        check("R7 expiry beats ack", irq, 1);
        do_ack("R6 read data zero");
        check("R6 plain ack clears", irq, 0);

        // R4: write at the same edge as an expiry
        do_write(0);
        tick(39);
        do_write(0);
        check("R4 write beats expiry", irq, 0);
        tick(39);
        check("R4 restart before expiry", irq, 0);
        tick(1);
        check("R4 restart expiry", irq, 1);

        // R8: disabled cycles do not count
        do_write(0);
        tick_en = 1'b0;
        tick(100);
        check("R8 no expiry while disabled", irq, 0);
        tick_en = 1'b1;
        tick(39);
        check("R8 before shifted expiry", irq, 0);
        tick(1);
        check("R8 shifted expiry", irq, 1);

        // R3: saturated reload
        do_write(5000);
        tick(TPS - 1);
        check("R3 before one-second expiry", irq, 0);
        tick(1);
        check("R3 one-second expiry", irq, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule